// File: doc/BRIEF.md
# Constant On-Time Gate Sequencer

This block is the digital timing core of a buck controller that uses constant on-time. It has no internal switching clock. A switching period begins when the feedback comparator reports that the output is below its target. Before it can begin, the minimum off interval must have elapsed and the valley over-current comparator must be quiet. The high-side enable then stays on for a programmed number of clock cycles. After that the low side takes over, with break-before-make gaps in both directions.

Two conduction modes are supported. In diode emulation the low-side enable drops when the zero-crossing comparator fires, so the period stretches at light load. In forced continuous conduction the zero-crossing input is ignored and the low side conducts until the next period. Three control inputs override the normal sequence:
- a disable input;
- a fault input;
- a low-side force input.

All durations are clock-cycle counts. Each count is loaded when its interval starts. A one-cycle pulse marks the start of every period, for use by neighbouring logic.

States: `ST_HALT` (both gates off, disabled or faulted), `ST_IDLE` (both off, waiting for demand), `ST_HS_ON` (high side on), `ST_DT_TRAIL` (gap after high side), `ST_LS_ON` (low side on), `ST_DT_LEAD` (gap before high side).

Transitions:
- HALT→IDLE when enabled and not faulted.
- IDLE→HS_ON on a start.
- IDLE→LS_ON on force.
- HS_ON→DT_TRAIL on on-time expiry or force.
- DT_TRAIL→LS_ON, or DT_TRAIL→IDLE when a zero crossing is seen in diode emulation, on gap expiry.
- LS_ON→IDLE on a zero crossing in diode emulation.
- LS_ON→DT_LEAD on a start.
- DT_LEAD→HS_ON on gap expiry.
- DT_LEAD→LS_ON on force.
- Any state→HALT when disabled or faulted.

Top module: `cot_gate_seq`

## Requirements
- R1: `hs_en` and `ls_en` are never both 1 in the same clock cycle.
- R2: A new period starts only from `ST_IDLE` or `ST_LS_ON`, and only in a cycle where `fb_below`=1, `valley_oc`=0 and the minimum off interval has elapsed. When `valley_oc`=1 the low side stays in its present state.
- R3: After a period starts, `hs_en` stays 1 for exactly max(`ton_cycles`,1) cycles unless the block is halted or forced. A count of 0 gives one cycle.
- R4: Between `hs_en` falling and its next rise there are at least max(`tmin_off_cycles`,1) cycles with `hs_en`=0. This does not apply when a halt intervenes; resuming from halt treats the minimum off interval as elapsed.
- R5: When the high side turns off, both enables stay 0 for exactly max(`tdead_cycles`,1) cycles before `ls_en` rises. When a start follows low-side conduction, both stay 0 for max(`tdead_cycles`,1) cycles before `hs_en` rises. `ls_en` never rises in the cycle right after `hs_en` was 1, and `hs_en` never rises in the cycle right after `ls_en` was 1.
- R6: With `mode_ccm`=0 (diode emulation), `zero_cross`=1 seen while the low side is on, or at the end of the trailing gap, leaves both enables 0 from the next cycle. A later start then raises `hs_en` directly from idle.
- R7: With `mode_ccm`=1, `zero_cross` has no effect and `ls_en` stays 1 until a start.
- R8: While `enable`=0 or `fault`=1, both enables are 0 from the cycle after the input is seen. A release returns the block to `ST_IDLE` without starting a period in the same cycle.
- R9: `force_ls`=1 ends any on-time at the next edge. The low side is then turned on through the normal trailing gap and held on. While it is held, `zero_cross`, `fb_below` and the mode are ignored. `force_ls`=1 is overridden by R8.
- R10: `cycle_start` is 1 for exactly the first cycle of each high-side on-time and is 0 at all other times.
- R11: During and straight after reset both enables and `cycle_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | 1 = operate, 0 = hold both gates off |
| fault | input | 1 | 1 = hold both gates off |
| force_ls | input | 1 | 1 = end on-time and hold low side on |
| mode_ccm | input | 1 | 1 = forced continuous conduction, 0 = diode emulation |
| fb_below | input | 1 | Feedback comparator: output below target |
| valley_oc | input | 1 | Valley over-current comparator |
| zero_cross | input | 1 | Inductor current reached zero |
| ton_cycles | input | ON_W | On-time in clock cycles |
| tmin_off_cycles | input | OFF_W | Minimum off interval in clock cycles |
| tdead_cycles | input | DT_W | Dead time in clock cycles |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| cycle_start | output | 1 | Pulse on first on-time cycle |

## Verification
Two decisions can land on the same edge, and in each case the bench checks the enables on the cycle after.
- A start request can meet the end of the minimum off interval in the low-side state. This is provoked by holding `fb_below` high through the last off cycle. The expected result is that the leading gap begins exactly on that edge and not one cycle earlier.
- The trailing dead-time expiry can coincide with a zero crossing. In diode emulation the low side must never turn on. In continuous mode it must turn on.

The valley limit is raised in the very cycle that demand appears, and the bench checks that the low side holds. Force and fault are asserted in the middle of an on-time, and the bench checks that the cut is immediate.

// File: rtl/cot_pkg.sv
package cot_pkg;

    typedef enum logic [2:0] {
        ST_HALT     = 3'd0,
        ST_IDLE     = 3'd1,
        ST_HS_ON    = 3'd2,
        ST_DT_TRAIL = 3'd3,
        ST_LS_ON    = 3'd4,
        ST_DT_LEAD  = 3'd5
    } cot_state_t;

endpackage

// File: rtl/cot_interval_timer.sv
// Loadable down counter. last=1 marks the final cycle of an interval
// whose length is max(load_val,1).
module cot_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt <= W'(1));
endmodule

// File: rtl/cot_gate_fsm.sv
module cot_gate_fsm
    import cot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic fault,
    input  logic force_ls,
    input  logic mode_ccm,
    input  logic fb_below,
    input  logic valley_oc,
    input  logic zero_cross,
    input  logic ph_last,
    input  logic mo_last,
    output logic ph_load,
    output logic ph_is_on,
    output logic mo_load,
    output logic mo_clear,
    output logic hs_en,
    output logic ls_en,
    output logic cycle_start
);
    cot_state_t st, nxt;
    logic halt, start_ok, zc_stop;

    assign halt     = !enable || fault;
    assign start_ok = fb_below && !valley_oc && mo_last;
    assign zc_stop  = !mode_ccm && zero_cross;

    // State register and start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_HALT;
            cycle_start <= 1'b0;
        end else begin
            st          <= nxt;
            cycle_start <= (nxt == ST_HS_ON) && (st != ST_HS_ON);
        end
    end

    // Next state and interval loads
    always_comb begin
        nxt      = st;
        ph_load  = 1'b0;
        ph_is_on = 1'b0;
        mo_load  = 1'b0;
        mo_clear = 1'b0;
        if (halt) begin
            nxt      = ST_HALT;
            mo_load  = 1'b1;
            mo_clear = 1'b1;
        end else begin
            unique case (st)
                ST_HALT: nxt = ST_IDLE;
                ST_IDLE: begin
                    if (force_ls) begin
                        nxt = ST_LS_ON;
                    end else if (start_ok) begin
                        nxt      = ST_HS_ON;
                        ph_load  = 1'b1;
                        ph_is_on = 1'b1;
                    end
                end
                ST_HS_ON: begin
                    if (ph_last || force_ls) begin
                        nxt     = ST_DT_TRAIL;
                        ph_load = 1'b1;
                        mo_load = 1'b1;
                    end
                end
                ST_DT_TRAIL: begin
                    if (ph_last) begin
                        nxt = (zc_stop && !force_ls) ? ST_IDLE : ST_LS_ON;
                    end
                end
                ST_LS_ON: begin
                    if (force_ls) begin
                        nxt = ST_LS_ON;
                    end else if (zc_stop) begin
                        nxt = ST_IDLE;
                    end else if (start_ok) begin
                        nxt     = ST_DT_LEAD;
                        ph_load = 1'b1;
                    end
                end
                ST_DT_LEAD: begin
                    if (force_ls) begin
                        nxt = ST_LS_ON;
                    end else if (ph_last) begin
                        nxt      = ST_HS_ON;
                        ph_load  = 1'b1;
                        ph_is_on = 1'b1;
                    end
                end
                default: nxt = ST_HALT;
            endcase
        end
    end

    // Gate decode
    always_comb begin
        hs_en = (st == ST_HS_ON);
        ls_en = (st == ST_LS_ON);
    end
endmodule

// File: rtl/cot_gate_seq.sv
module cot_gate_seq #(
    parameter int ON_W  = 10,
    parameter int OFF_W = 8,
    parameter int DT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fault,
    input  logic             force_ls,
    input  logic             mode_ccm,
    input  logic             fb_below,
    input  logic             valley_oc,
    input  logic             zero_cross,
    input  logic [ON_W-1:0]  ton_cycles,
    input  logic [OFF_W-1:0] tmin_off_cycles,
    input  logic [DT_W-1:0]  tdead_cycles,
    output logic             hs_en,
    output logic             ls_en,
    output logic             cycle_start
);
    localparam int PH_W = (ON_W > DT_W) ? ON_W : DT_W;

    logic            ph_load, ph_is_on, ph_last;
    logic            mo_load, mo_clear, mo_last;
    logic [PH_W-1:0] ph_val;
    logic [OFF_W-1:0] mo_val;

    assign ph_val = ph_is_on ? PH_W'(ton_cycles) : PH_W'(tdead_cycles);
    assign mo_val = mo_clear ? '0 : tmin_off_cycles;

    cot_interval_timer #(.W(PH_W)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .last     (ph_last)
    );

    cot_interval_timer #(.W(OFF_W)) u_minoff_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mo_load),
        .load_val (mo_val),
        .last     (mo_last)
    );

    cot_gate_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .fault       (fault),
        .force_ls    (force_ls),
        .mode_ccm    (mode_ccm),
        .fb_below    (fb_below),
        .valley_oc   (valley_oc),
        .zero_cross  (zero_cross),
        .ph_last     (ph_last),
        .mo_last     (mo_last),
        .ph_load     (ph_load),
        .ph_is_on    (ph_is_on),
        .mo_load     (mo_load),
        .mo_clear    (mo_clear),
        .hs_en       (hs_en),
        .ls_en       (ls_en),
        .cycle_start (cycle_start)
    );
endmodule

// File: rtl/cot_gate_seq_chk.sv
module cot_gate_seq_chk #(
    parameter int OFF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             fault,
    input logic             fb_below,
    input logic             valley_oc,
    input logic [OFF_W-1:0] tmin_off_cycles,
    input logic             hs_en,
    input logic             ls_en,
    input logic             cycle_start
);
    localparam int CW = OFF_W + 2;

    logic          hs_q, armed;
    logic [CW-1:0] off_cnt;
    logic [CW-1:0] need;
    logic [CW-1:0] need_eff;

    assign need_eff = (need == '0) ? CW'(1) : need;

    // Counts high-side-off cycles since the last fall; a halt disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q    <= 1'b0;
            armed   <= 1'b0;
            off_cnt <= '0;
            need    <= '0;
        end else begin
            hs_q <= hs_en;
            if (!enable || fault) begin
                armed <= 1'b0;
            end else if (hs_q && !hs_en) begin
                armed   <= 1'b1;
                off_cnt <= CW'(1);
                need    <= CW'(tmin_off_cycles);
            end else if (!hs_en && (off_cnt != {CW{1'b1}})) begin
                off_cnt <= off_cnt + 1'b1;
            end
        end
    end

    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    a_r2_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> ($past(fb_below) && !$past(valley_oc)));

    a_r4_min_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> (!armed || (off_cnt >= need_eff)));

    a_r5_gap_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> !$past(hs_en));

    a_r5_gap_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> !$past(ls_en));

    a_r8_halt_gates_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || fault) |=> (!hs_en && !ls_en));

    a_r10_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> cycle_start);

    a_r10_pulse_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> (hs_en && !$past(hs_en)));
endmodule

bind cot_gate_seq cot_gate_seq_chk #(.OFF_W(OFF_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable          (enable),
    .fault           (fault),
    .fb_below        (fb_below),
    .valley_oc       (valley_oc),
    .tmin_off_cycles (tmin_off_cycles),
    .hs_en           (hs_en),
    .ls_en           (ls_en),
    .cycle_start     (cycle_start)
);

// File: tb/cot_gate_seq_tb_top.sv
module cot_gate_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 42;

    // {enable, fault, force_ls, mode_ccm, fb_below, valley_oc, zero_cross,
    //  exp hs_en, exp ls_en, exp cycle_start}; ton=3, tmin=4, dead=2
    localparam logic [9:0] VEC [NVEC] = '{
        10'b1000000_000, 10'b1000110_000, 10'b1000100_101, 10'b1000100_100,
        10'b1000100_100, 10'b1000100_000, 10'b1000100_000, 10'b1000100_010,
        10'b1000100_010, 10'b1000100_000, 10'b1000100_000, 10'b1000100_101,
        10'b1000000_100, 10'b1000000_100, 10'b1000000_000, 10'b1000000_000,
        10'b1000000_010, 10'b1000001_000, 10'b1000000_000, 10'b1000100_101,
        10'b1000000_100, 10'b1000000_100, 10'b1000000_000, 10'b1001001_000,
        10'b1001001_010, 10'b1001001_010, 10'b1001001_010, 10'b1001111_010,
        10'b1001101_000, 10'b1001101_000, 10'b1001101_101, 10'b1011000_000,
        10'b1011000_000, 10'b1011000_010, 10'b1010101_010, 10'b1000000_010,
        10'b1100000_000, 10'b1100100_000, 10'b1000100_000, 10'b1000100_101,
        10'b0000100_000, 10'b0000100_000
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, fault = 1'b0, force_ls = 1'b0, mode_ccm = 1'b0;
    logic       fb_below = 1'b0, valley_oc = 1'b0, zero_cross = 1'b0;
    logic [9:0] ton_cycles = 10'd3;
    logic [7:0] tmin_off_cycles = 8'd4;
    logic [3:0] tdead_cycles = 4'd2;
    logic       hs_en, ls_en, cycle_start;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cot_gate_seq dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .enable          (enable),
        .fault           (fault),
        .force_ls        (force_ls),
        .mode_ccm        (mode_ccm),
        .fb_below        (fb_below),
        .valley_oc       (valley_oc),
        .zero_cross      (zero_cross),
        .ton_cycles      (ton_cycles),
        .tmin_off_cycles (tmin_off_cycles),
        .tdead_cycles    (tdead_cycles),
        .hs_en           (hs_en),
        .ls_en           (ls_en),
        .cycle_start     (cycle_start)
    );

    function automatic string req_of(int i);
        if (i == 0)                 return "R8";
        else if (i == 1 || i == 27) return "R2";
        else if (i == 2 || i == 11 || i == 30) return "R10";
        else if (i <= 4)            return "R3";
        else if (i <= 6)            return "R5";
        else if (i <= 8)            return "R4";
        else if (i <= 10)           return "R5";
        else if (i <= 13)           return "R3";
        else if (i <= 16)           return "R5";
        else if (i <= 19)           return "R6";
        else if (i <= 22)           return "R3";
        else if (i <= 26)           return "R7";
        else if (i <= 29)           return "R5";
        else if (i <= 35)           return "R9";
        else                        return "R8";
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        int n;
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11", {hs_en, ls_en, cycle_start}, 0);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            {enable, fault, force_ls, mode_ccm, fb_below, valley_oc, zero_cross} = VEC[i][9:3];
            @(negedge clk);
            check(req_of(i), {hs_en, ls_en, cycle_start}, int'(VEC[i][2:0]));
        end

        // Directed: zero on-time count (R3), long dead time both ways (R5)
        ton_cycles      = 10'd0;
        tdead_cycles    = 4'd5;
        tmin_off_cycles = 8'd1;
        {enable, fault, force_ls, mode_ccm, fb_below, valley_oc, zero_cross} = 7'b1001100;
        for (int k = 0; k < 50 && hs_en !== 1'b1; k++) @(negedge clk);
        n = 0;
        while (hs_en) begin n++; @(negedge clk); end
        check("R3", n, 1);
        n = 0;
        while (!hs_en && !ls_en) begin n++; @(negedge clk); end
        check("R5", n, 5);
        n = 0;
        while (ls_en) begin n++; @(negedge clk); end
        check("R4", n, 1);
        n = 0;
        while (!hs_en && !ls_en) begin n++; @(negedge clk); end
        check("R5", n, 5);

        finish_run();
    end
endmodule